// File: doc/BRIEF.md
# Watchdog Timer with Alternating Clear Key

This block is a watchdog counter that runs from a slow clock and is serviced by software over a simple register bus on the fast system clock. Software keeps the watchdog quiet by writing a key byte to one 8-bit control register. The key that is accepted alternates between two values. A one-bit pointer selects the current key, and that pointer inverts on every write that is accepted, whether or not the key was correct. A read of the register shows the pointer in bit 0, so software can confirm that its write took effect.

If the counter wraps without a valid clear, the watchdog raises an interrupt. If it wraps a second time with still no valid clear, it pulses a system reset request. Each wrap starts a short initialisation window. During that window the pointer is held at 0 and bus writes are dropped. Clear requests reach the slow domain through a toggle handshake that is synchronised in both directions. The interrupt and reset outputs are one-cycle pulses in the slow-clock domain.

Top module: `wdk_top`

## Requirements
- R1: After reset the register reads 00h, and neither the interrupt nor the reset request is asserted.
- R2: A read returns the pointer in bit 0 and zeros in bits 7 to 1.
- R3: Every write that falls outside the initialisation window inverts the pointer, whatever the data byte.
- R4: Writing 5Ah while the pointer is 0, or A5h while the pointer is 1, returns the counter to zero. Valid clears issued at intervals shorter than the timeout keep both outputs quiet indefinitely.
- R5: Any other byte, including the key that belongs to the opposite pointer value, leaves the counter running. The interrupt then arrives at the same slow cycle it would have arrived at with no write.
- R6: With no valid clear, the interrupt pulses for one slow cycle exactly 2^CNT_W slow cycles after the counter last started from zero.
- R7: A second wrap with no valid clear since the interrupt pulses the reset request for one slow cycle, 2^CNT_W slow cycles after the interrupt. The interrupt and the reset request are never high together.
- R8: A valid clear after the interrupt re-arms the first stage, so the next wrap raises the interrupt again and not the reset request.
- R9: Every wrap opens an initialisation window of one slow cycle, seen in the bus domain after synchronisation. During it the pointer reads 0, writes neither toggle the pointer nor clear the counter, and the pointer is left at 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bus clock |
| slow_clk_i | input | 1 | Slow watchdog counting clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write qualifier for the access |
| wdata_i | input | 8 | Write data (key byte) |
| rdata_o | output | 8 | Read data: pointer in bit 0, zeros above |
| wdt_irq_o | output | 1 | First-wrap interrupt pulse (slow domain) |
| wdt_rst_o | output | 1 | Second-wrap reset request pulse (slow domain) |

## Verification
The bench sweeps every byte value other than the two keys. It also writes each key while the pointer selects the other one. In every case the interrupt must land on exactly the slow cycle of an untouched counter, so a key check that compares loosely, or that ignores the pointer, would shift that cycle. Writes are placed inside the initialisation window after the first wrap. If the design still honoured such a write, either the pointer would read 1 or the reset request would move away from cycle 2·2^CNT_W. A valid clear after the interrupt must give a second interrupt and no reset request, which exposes a design that fails to re-arm. Further checks read the pointer back after each write, confirm the pointer drops to 0 across a wrap, and confirm that regular valid clears keep both outputs silent.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;
  localparam logic [7:0] KEY_PTR0 = 8'h5A;
  localparam logic [7:0] KEY_PTR1 = 8'hA5;

  // key expected for the current pointer value
  function automatic logic [7:0] key_for(input logic ptr);
    return ptr ? KEY_PTR1 : KEY_PTR0;
  endfunction

  function automatic logic key_match(input logic [7:0] data, input logic ptr);
    return data == key_for(ptr);
  endfunction

  function automatic logic [7:0] ctl_readback(input logic ptr);
    return {7'b0000000, ptr};
  endfunction
endpackage

// File: rtl/wdk_sync.sv
`timescale 1ns/1ps
module wdk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], d_i};
  end

  assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/wdk_ctl.sv
`timescale 1ns/1ps
module wdk_ctl
  import wdk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       lock_i,
  input  logic       ack_i,
  output logic       req_o
);
  logic ptr_q, req_q, pend_q;
  logic wr_fire, wr_take, key_hit, busy, launch;

  assign wr_fire = sel_i & we_i;
  assign wr_take = wr_fire & ~lock_i;
  assign key_hit = wr_take & key_match(wdata_i, ptr_q);
  assign busy    = req_q ^ ack_i;
  assign launch  = (pend_q | key_hit) & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= 1'b0;
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (lock_i)       ptr_q <= 1'b0;
      else if (wr_take) ptr_q <= ~ptr_q;
      req_q  <= req_q ^ launch;
      pend_q <= (pend_q | key_hit) & ~launch;
    end
  end

  assign rdata_o = ctl_readback(ptr_q);
  assign req_o   = req_q;

  a_r3_ptr_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_take |=> (ptr_q != $past(ptr_q)));
  a_r9_lock_holds_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> (ptr_q == 1'b0));
  a_r4_req_stable_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(req_q));
  a_r4_hit_not_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_hit |=> (pend_q || (req_q != $past(req_q))));
endmodule

// File: rtl/wdk_core.sv
`timescale 1ns/1ps
module wdk_core #(
  parameter int CNT_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic ack_o,
  output logic lock_o,
  output logic irq_o,
  output logic rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic ack_q, armed_q, irq_q, rstr_q, lock_q;
  logic clr, ovf_evt;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c, input logic clear);
    return clear ? '0 : c + 1'b1;
  endfunction

  assign clr     = req_i ^ ack_q;
  assign ovf_evt = (&cnt_q) & ~clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      rstr_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_next(cnt_q, clr);
      ack_q  <= req_i;
      if (clr)          armed_q <= 1'b0;
      else if (ovf_evt) armed_q <= ~armed_q;
      irq_q  <= ovf_evt & ~armed_q;
      rstr_q <= ovf_evt & armed_q;
      lock_q <= ovf_evt;
    end
  end

  assign ack_o     = ack_q;
  assign lock_o    = lock_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rstr_q;

  a_r6_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  a_r7_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_q && rstr_q));
  a_r4_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt_q == '0));
  a_r8_clear_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> ##1 !rstr_q);
endmodule

// File: rtl/wdk_top.sv
`timescale 1ns/1ps
module wdk_top #(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       slow_clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       wdt_irq_o,
  output logic       wdt_rst_o
);
  logic req_f, req_s, ack_s, ack_f, lock_s, lock_f;

  wdk_ctl u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lock_i(lock_f),
    .ack_i(ack_f), .req_o(req_f)
  );

  wdk_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .d_i(req_f), .q_o(req_s));
  wdk_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_s), .q_o(ack_f));
  wdk_sync #(.STAGES(SYNC_STAGES)) u_sync_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lock_s), .q_o(lock_f));

  wdk_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .req_i(req_s), .ack_o(ack_s),
    .lock_o(lock_s), .irq_o(wdt_irq_o), .rst_req_o(wdt_rst_o)
  );
endmodule

// File: tb/wdk_top_test.sv
`timescale 1ns/1ps
module wdk_top_test;
  localparam int CNT_W = 6;
  localparam int TMO   = 1 << CNT_W;

  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq, rstq;

  int checks = 0, errors = 0;
  int slow_cnt = 0, irq_n = 0, rst_n_cnt = 0;
  int irq1_at = 0, irq2_at = 0, rst1_at = 0, both_seen = 0;
  logic exp_ptr;

  wdk_top #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_n), .sel_i(sel),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .wdt_irq_o(irq),
    .wdt_rst_o(rstq));

  always #5 clk = ~clk;
  initial begin #3; forever #40 slow_clk = ~slow_clk; end

  always @(negedge slow_clk) begin
    if (rst_n) begin
      slow_cnt = slow_cnt + 1;
      if (irq && rstq) both_seen = 1;
      if (irq) begin
        irq_n = irq_n + 1;
        if (irq_n == 1) irq1_at = slow_cnt;
        if (irq_n == 2) irq2_at = slow_cnt;
      end
      if (rstq) begin
        rst_n_cnt = rst_n_cnt + 1;
        if (rst_n_cnt == 1) rst1_at = slow_cnt;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel = 1'b0; we = 1'b0;
    repeat (3) @(negedge slow_clk);
    #5;
    slow_cnt = 0; irq_n = 0; rst_n_cnt = 0;
    irq1_at = 0; irq2_at = 0; rst1_at = 0; both_seen = 0;
    exp_ptr = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [7:0] v);
    @(negedge clk); sel = 1'b1; we = 1'b1; wdata = v;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic wait_slow_to(input int n);
    while (slow_cnt < n) begin @(negedge slow_clk); #1; end
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // A: reset state and free-running wraps
    do_reset();
    @(negedge clk);
    check(rdata == 8'h00, "R1 rdata", rdata, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(rstq == 1'b0, "R1 rst", rstq, 0);
    wait_slow_to(3 * TMO + 4);
    check(irq1_at == TMO, "R6 first irq cycle", irq1_at, TMO);
    check(rst1_at == 2 * TMO, "R7 rst cycle", rst1_at, 2 * TMO);
    check(irq2_at == 3 * TMO, "R7 irq after rst", irq2_at, 3 * TMO);
    check(both_seen == 0, "R7 exclusive", both_seen, 0);

    // B: periodic valid keys keep it quiet
    do_reset();
    for (int k = 0; k < 15; k++) begin
      wait_slow_to(20 * (k + 1));
      bus_write(exp_ptr ? 8'hA5 : 8'h5A);
      exp_ptr = ~exp_ptr;
      @(negedge clk);
      check(rdata == {7'b0, exp_ptr}, "R2 R3 readback", rdata, {7'b0, exp_ptr});
    end
    wait_slow_to(310);
    check(irq_n == 0, "R4 no irq", irq_n, 0);
    check(rst_n_cnt == 0, "R4 no rst", rst_n_cnt, 0);

    // C: exhaustive wrong bytes in two halves, then swapped keys
    for (int h = 0; h < 2; h++) begin
      int n;
      n = 0;
      do_reset();
      wait_slow_to(2);
      for (int v = h * 128; v < h * 128 + 128; v++) begin
        if (v != 8'h5A && v != 8'hA5) begin
          bus_write(v[7:0]);
          n++;
        end
      end
      @(negedge clk);
      check(rdata == {7'b0, n[0]}, "R3 parity after sweep", rdata, n[0]);
      wait_slow_to(TMO + 2);
      check(irq1_at == TMO, "R5 wrong bytes no clear", irq1_at, TMO);
    end
    do_reset();
    wait_slow_to(2);
    for (int k = 0; k < 10; k++) bus_write(k[0] ? 8'h5A : 8'hA5);
    @(negedge clk);
    check(rdata == 8'h00, "R3 swapped keys parity", rdata, 0);
    wait_slow_to(TMO + 2);
    check(irq1_at == TMO, "R5 swapped keys no clear", irq1_at, TMO);

    // D: lockout after first wrap, then re-arm by a valid clear
    do_reset();
    wait_slow_to(4);
    bus_write(8'h00);
    wait_slow_to(TMO - 4);
    @(negedge clk);
    check(rdata == 8'h01, "R3 ptr before wrap", rdata, 1);
    wait_slow_to(TMO);
    @(negedge clk);
    check(rdata == 8'h00, "R9 ptr cleared at wrap", rdata, 0);
    bus_write(8'h5A);
    check(rdata == 8'h00, "R9 write ignored in window", rdata, 0);
    wait_slow_to(TMO + 3);
    @(negedge clk);
    check(rdata == 8'h00, "R9 ptr stays 0", rdata, 0);
    bus_write(8'h5A);
    @(negedge clk);
    check(rdata == 8'h01, "R8 valid write accepted", rdata, 1);
    wait_slow_to(190);
    check(irq2_at >= 2 * TMO + 2 && irq2_at <= 2 * TMO + 8, "R8 second irq", irq2_at, 2 * TMO + 5);
    check(rst_n_cnt == 0, "R8 no rst after rearm", rst_n_cnt, 0);

    // E: key written in the window must not clear the counter
    do_reset();
    wait_slow_to(TMO);
    @(negedge clk);
    bus_write(8'h5A);
    check(rdata == 8'h00, "R9 ptr unchanged", rdata, 0);
    wait_slow_to(2 * TMO + 3);
    check(rst1_at == 2 * TMO, "R9 window write did not clear", rst1_at, 2 * TMO);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule